// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Polarity Driver

This block is the digital core of a multi-channel segment driver. A serial bit stream, qualified by a slow serial clock, is shifted into a chain of stages, one stage per parallel output. A low-active capture enable copies the stage contents into a holding register. A polarity select either passes the held pattern straight to the outputs or inverts every output together. It also sets a companion backplane output to the level that matches the chosen polarity. The last stage is presented on a cascade output that moves on the falling serial clock edge. A second device can take that output as its serial input and sample it on its own next rising edge, so any number of devices can share one clock and one capture enable.

The core runs on a fast system clock. The serial clock and serial data pass through a synchronizer before they are used, and the rising and falling serial edges are detected on the synchronized level. The capture enable and the polarity select are used directly. The polarity path is purely combinational.

Top module: `seg_polarity_driver`

## Requirements
- R1: On each detected rising serial clock edge the stage chain shifts by one. The synchronized serial data enters stage 1, which drives `par_out[0]`, and each stage k takes the old value of stage k-1. Between rising edges the chain does not change.
- R2: The chain has NUM_CH (default 16) stages. When two devices are chained through the cascade output and 2*NUM_CH bits are shifted, the downstream device holds the first NUM_CH bits sent and the upstream device holds the last NUM_CH bits. The earliest bit sent ends up in the highest stage.
- R3: `ser_dout` equals the last stage as sampled on a detected falling serial clock edge. It changes on no other edge.
- R4: While `latch_en_n` is high the held pattern does not change, and shifting new serial data has no effect on `par_out`.
- R5: While `latch_en_n` is low, the held pattern takes the chain contents on every system clock edge, with one system cycle of lag.
- R6: With `pol_n` high, each `par_out` bit equals its held bit and `bp` is 0.
- R7: With `pol_n` low, each `par_out` bit is the inverse of its held bit and `bp` is 1.
- R8: A change on `pol_n` reaches `par_out` and `bp` in the same cycle, without waiting for any clock edge.
- R9: A synchronous reset (`rst` high at a system clock edge) clears the chain, the held pattern, the cascade output and the synchronizers. With `pol_n` high, all outputs are then 0.
- R10: A rise on `ser_clk` shifts the chain at the third system clock edge after the rise. With `latch_en_n` low, the new stage-1 value appears on `par_out[0]` after the fourth edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous to clk |
| ser_din | input | 1 | Serial data, stable around the rising serial edge |
| latch_en_n | input | 1 | Capture enable, low = transparent, high = hold |
| pol_n | input | 1 | Polarity select, high = direct, low = inverted |
| par_out | output | NUM_CH | Parallel outputs, bit 0 is channel 1 |
| bp | output | 1 | Backplane level, inverse of pol_n |
| ser_dout | output | 1 | Cascade output, last stage updated on falling serial edge |

## Verification
A shift and a capture can fall in the same system cycle. The bench provokes this by holding `latch_en_n` low while serial bits keep arriving. The held pattern must then take the pre-shift chain value on the shift cycle and the shifted value one cycle later. A polarity flip can also coincide with a shift or a capture. The bench toggles `pol_n` during a transparent window. A behavioural per-cycle model, driven from the port stimulus, judges every cycle of both chained devices, and directed checks at the ports back it up.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  // Output level of one channel for a held bit and the polarity select.
  function automatic logic polar_bit(input logic held, input logic pol_sel_n);
    return pol_sel_n ? held : ~held;
  endfunction

  // Backplane level that matches the polarity select.
  function automatic logic backplane_level(input logic pol_sel_n);
    return ~pol_sel_n;
  endfunction

endpackage

// File: rtl/seg_sync_pipe.sv
module seg_sync_pipe #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int BITS = STAGES * W;

  logic [BITS-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[BITS-W-1:0], d};
      end
    end
  endgenerate

  assign q = pipe_q[BITS-1 -: W];
endmodule

// File: rtl/seg_edge_detect.sv
module seg_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_evt,
  input  logic              present_evt,
  input  logic              din,
  output logic [NUM_CH-1:0] stages,
  output logic              cascade_out
);
  localparam int LAST = NUM_CH - 1;

  logic [NUM_CH-1:0] stage_q;
  logic              casc_q;

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_stage
      logic feed;
      if (k == 0) begin : g_head
        assign feed = din;
      end else begin : g_body
        assign feed = stage_q[k-1];
      end
      always_ff @(posedge clk) begin
        if (rst)            stage_q[k] <= 1'b0;
        else if (shift_evt) stage_q[k] <= feed;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)              casc_q <= 1'b0;
    else if (present_evt) casc_q <= stage_q[LAST];
  end

  assign stages      = stage_q;
  assign cascade_out = casc_q;
endmodule

// File: rtl/seg_hold_latch.sv
module seg_hold_latch #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_n,
  input  logic [NUM_CH-1:0] d,
  output logic [NUM_CH-1:0] q
);
  logic [NUM_CH-1:0] held_q;

  always_ff @(posedge clk) begin
    if (rst)             held_q <= '0;
    else if (!capture_n) held_q <= d;
  end

  assign q = held_q;
endmodule

// File: rtl/seg_polarity_stage.sv
module seg_polarity_stage #(
  parameter int NUM_CH = 16
) (
  input  logic [NUM_CH-1:0] held,
  input  logic              pol_sel_n,
  output logic [NUM_CH-1:0] drive,
  output logic              backplane
);
  import seg_drv_pkg::*;

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign drive[c] = polar_bit(held[c], pol_sel_n);
    end
  endgenerate

  assign backplane = backplane_level(pol_sel_n);
endmodule

// File: rtl/seg_polarity_driver.sv
module seg_polarity_driver #(
  parameter int NUM_CH      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              latch_en_n,
  input  logic              pol_n,
  output logic [NUM_CH-1:0] par_out,
  output logic              bp,
  output logic              ser_dout
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] raw_pair;
  logic [SYNC_W-1:0] sync_pair;
  logic              ser_clk_s;
  logic              din_s;
  logic              rise_evt;
  logic              fall_evt;
  logic [NUM_CH-1:0] sr_state;
  logic [NUM_CH-1:0] latch_state;

  assign raw_pair  = {ser_clk, ser_din};
  assign ser_clk_s = sync_pair[1];
  assign din_s     = sync_pair[0];

  seg_sync_pipe #(.STAGES(SYNC_STAGES), .W(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_pair),
    .q   (sync_pair)
  );

  seg_edge_detect u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (ser_clk_s),
    .rise  (rise_evt),
    .fall  (fall_evt)
  );

  seg_shift_chain #(.NUM_CH(NUM_CH)) u_chain (
    .clk         (clk),
    .rst         (rst),
    .shift_evt   (rise_evt),
    .present_evt (fall_evt),
    .din         (din_s),
    .stages      (sr_state),
    .cascade_out (ser_dout)
  );

  seg_hold_latch #(.NUM_CH(NUM_CH)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .capture_n (latch_en_n),
    .d         (sr_state),
    .q         (latch_state)
  );

  seg_polarity_stage #(.NUM_CH(NUM_CH)) u_pol (
    .held      (latch_state),
    .pol_sel_n (pol_n),
    .drive     (par_out),
    .backplane (bp)
  );
endmodule

// File: rtl/seg_polarity_checker.sv
module seg_polarity_checker #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              latch_en_n,
  input logic              pol_n,
  input logic              rise_evt,
  input logic              fall_evt,
  input logic              din_s,
  input logic [NUM_CH-1:0] sr_state,
  input logic [NUM_CH-1:0] latch_state,
  input logic [NUM_CH-1:0] par_out,
  input logic              bp,
  input logic              ser_dout
);
  a_r1_shift: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> (sr_state[0] == $past(din_s)) &&
                 (sr_state[NUM_CH-1:1] == $past(sr_state[NUM_CH-2:0])));

  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !rise_evt |=> $stable(sr_state));

  a_r1_edges_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_evt, fall_evt}));

  a_r3_dout_on_fall: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> ser_dout == $past(sr_state[NUM_CH-1]));

  a_r3_dout_quiet: assert property (@(posedge clk) disable iff (rst)
    !fall_evt |=> $stable(ser_dout));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    latch_en_n |=> $stable(latch_state));

  a_r5_follow: assert property (@(posedge clk) disable iff (rst)
    !latch_en_n |=> latch_state == $past(sr_state));

  a_r6_direct: assert property (@(posedge clk) disable iff (rst)
    pol_n |-> (par_out == latch_state) && !bp);

  a_r7_invert: assert property (@(posedge clk) disable iff (rst)
    !pol_n |-> (par_out == ~latch_state) && bp);

  a_r9_reset: assert property (@(posedge clk)
    rst |=> (sr_state == '0) && (latch_state == '0) && !ser_dout);
endmodule

bind seg_polarity_driver seg_polarity_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk         (clk),
  .rst         (rst),
  .latch_en_n  (latch_en_n),
  .pol_n       (pol_n),
  .rise_evt    (rise_evt),
  .fall_evt    (fall_evt),
  .din_s       (din_s),
  .sr_state    (sr_state),
  .latch_state (latch_state),
  .par_out     (par_out),
  .bp          (bp),
  .ser_dout    (ser_dout)
);

// File: tb/seg_polarity_driver_bench.sv
`timescale 1ns/1ps
module seg_polarity_driver_bench;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_din = 1'b0;
  logic latch_en_n = 1'b1;
  logic pol_n = 1'b1;
  logic [N-1:0] out_a, out_b;
  logic bp_a, bp_b, dout_a, dout_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_polarity_driver u_seg_polarity_driver (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .latch_en_n(latch_en_n), .pol_n(pol_n),
    .par_out(out_a), .bp(bp_a), .ser_dout(dout_a));

  seg_polarity_driver u_seg_polarity_driver_dn (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(dout_a),
    .latch_en_n(latch_en_n), .pol_n(pol_n),
    .par_out(out_b), .bp(bp_b), .ser_dout(dout_b));

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference: serial history kept as queues, one entry per system edge.
  bit ck_hist[$];
  bit da_hist[$];
  bit db_hist[$];
  logic [N-1:0] m_sr_a = '0, m_sr_b = '0, m_lat_a = '0, m_lat_b = '0;
  logic m_do_a = 1'b0, m_do_b = 1'b0;

  always @(posedge clk) begin
    #1;
    if (rst) begin
      ck_hist = '{0, 0, 0}; da_hist = '{0, 0, 0}; db_hist = '{0, 0, 0};
      m_sr_a = '0; m_sr_b = '0; m_lat_a = '0; m_lat_b = '0;
      m_do_a = 1'b0; m_do_b = 1'b0;
    end else begin
      logic up, down, prev_do_a;
      logic [N-1:0] prev_a, prev_b;
      up = ck_hist[1] && !ck_hist[2];
      down = !ck_hist[1] && ck_hist[2];
      prev_a = m_sr_a; prev_b = m_sr_b; prev_do_a = m_do_a;
      if (up) begin
        m_sr_a = {prev_a[N-2:0], da_hist[1]};
        m_sr_b = {prev_b[N-2:0], db_hist[1]};
      end
      if (down) begin
        m_do_a = prev_a[N-1];
        m_do_b = prev_b[N-1];
      end
      if (!latch_en_n) begin
        m_lat_a = prev_a;
        m_lat_b = prev_b;
      end
      ck_hist.push_front(ser_clk); void'(ck_hist.pop_back());
      da_hist.push_front(ser_din); void'(da_hist.pop_back());
      db_hist.push_front(prev_do_a); void'(db_hist.pop_back());
    end
    if (!done) begin
      chk("R6/R7 model par_out A", out_a, pol_n ? m_lat_a : ~m_lat_a);
      chk("R6/R7 model par_out B", out_b, pol_n ? m_lat_b : ~m_lat_b);
      chk("R6/R7 model bp", {bp_b, bp_a}, {2{~pol_n}});
      chk("R3 model ser_dout", {dout_b, dout_a}, {m_do_b, m_do_a});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_din = b;
    cyc(4); ser_clk = 1'b1;
    cyc(8); ser_clk = 1'b0;
    cyc(4);
  endtask

  task automatic send_word(input logic [2*N-1:0] w);
    for (int k = 0; k < 2*N; k++) send_bit(w[k]);
    cyc(8);
  endtask

  task automatic capture();
    @(negedge clk); latch_en_n = 1'b0;
    cyc(3); latch_en_n = 1'b1;
    cyc(2);
  endtask

  // Expected held pattern after 2N bits sent bit 0 first (R2).
  function automatic logic [N-1:0] pat_up(input logic [2*N-1:0] w);
    for (int i = 0; i < N; i++) pat_up[i] = w[2*N-1-i];
  endfunction
  function automatic logic [N-1:0] pat_dn(input logic [2*N-1:0] w);
    for (int i = 0; i < N; i++) pat_dn[i] = w[N-1-i];
  endfunction

  localparam logic [2*N-1:0] W1 = 32'hA5C3_1E69;
  localparam logic [2*N-1:0] W2 = 32'h0FF0_9C36;

  initial begin
    cyc(5);
    @(negedge clk); rst = 1'b0;
    cyc(1);
    chk("R9 reset par_out A", out_a, '0);
    chk("R9 reset par_out B", out_b, '0);
    chk("R9 reset dout/bp", {dout_a, dout_b, bp_a}, 3'b000);

    // R10: latency from a serial rise to par_out[0] in transparent mode.
    @(negedge clk); latch_en_n = 1'b0; ser_din = 1'b1;
    cyc(4); ser_clk = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk); #1;
    chk("R10 not yet after third edge", out_a, '0);
    @(posedge clk); #1;
    chk("R10 stage1 after fourth edge", out_a, 16'h0001);
    cyc(8); ser_clk = 1'b0; latch_en_n = 1'b1;
    cyc(6);

    @(negedge clk); rst = 1'b1; cyc(1); rst = 1'b0; cyc(1);
    chk("R9 mid-run reset clears", out_a, '0);

    // R4: shifting with capture held off leaves outputs alone.
    send_word(W1);
    chk("R4 hold during shift A", out_a, '0);
    chk("R4 hold during shift B", out_b, '0);
    capture();
    chk("R2 R5 upstream pattern", out_a, pat_up(W1));
    chk("R2 R5 downstream pattern", out_b, pat_dn(W1));
    chk("R6 bp low", {15'd0, bp_a}, '0);

    // R7/R8: polarity acts in the same cycle.
    @(negedge clk); pol_n = 1'b0; #1;
    chk("R8 R7 immediate invert A", out_a, ~pat_up(W1));
    chk("R7 invert B", out_b, ~pat_dn(W1));
    chk("R7 bp high", {15'd0, bp_a}, 16'd1);
    @(negedge clk); pol_n = 1'b1; #1;
    chk("R8 R6 immediate restore", out_a, pat_up(W1));

    send_word(W2);
    chk("R4 hold with new data A", out_a, pat_up(W1));
    chk("R4 hold with new data B", out_b, pat_dn(W1));
    capture();
    chk("R2 second word upstream", out_a, pat_up(W2));
    chk("R2 second word downstream", out_b, pat_dn(W2));

    // Shift and capture together, polarity flipped mid-window.
    @(negedge clk); latch_en_n = 1'b0;
    send_bit(1'b1);
    pol_n = 1'b0;
    send_bit(1'b0);
    send_bit(1'b1);
    pol_n = 1'b1;
    cyc(6);
    chk("R1 R5 transparent shift A", out_a, {pat_up(W2)[N-4:0], 3'b101});
    @(negedge clk); latch_en_n = 1'b1;
    cyc(4);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    done = 1;
    $display("FAIL watchdog R1: run did not finish, got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule